// File: doc/BRIEF.md
# Dual-ALU Steering and Address Interlock Control

This block is the decode-stage control for a five-stage pipeline (fetch, decode, EX1, EX2/memory, writeback) that has one ALU in EX1 and a second in EX2. For each ALU instruction in decode it decides which ALU runs it. The early ALU is used when the operands are ready by the end of decode. The late ALU is used when an operand only arrives at the end of EX1. Because the choice is made per instruction and without a stall, ALU instructions never wait.

Memory instructions need their base register by the end of decode. The block raises a stall when that base comes from the instruction now in EX1 and that instruction only produces its value at the end of EX2/memory. This happens when the EX1 instruction is a load or an ALU op that was itself steered to the late ALU. The store data operand is needed only by the end of EX1, so it never causes a stall. The block owns the control slice of the decode/EX1 pipeline register: the destination, write enable, class and late-ALU flag. On a stall it places a bubble in EX1, and the instruction in decode is held by the surrounding pipeline.

Top module: `dual_alu_steer_ctl`

## Requirements
- R1: After reset, and after each later reset, the EX1 slice holds class NOP (0) with write enable 0 and late-ALU flag 0, and decode NOP produces no stall and no late-ALU select.
- R2: Class codes are NOP=0, ALU=1, ALUI=2, LOAD=3, STORE=4, BRANCH=5, JUMP=6, and only ALU, ALUI and LOAD write a register. When there is no stall, the next clock copies the decode class, destination, write enable and late-ALU select into the EX1 slice.
- R3: An ALU or ALUI instruction in decode selects the late ALU when its rs equals the EX1 destination and that EX1 instruction is a late producer. A late producer writes a nonzero destination and is a LOAD or has its late-ALU flag set.
- R4: The rt field takes part in steering only when the rt read enable is 1.
- R5: An EX1 destination of register 0 never causes late-ALU select or stall.
- R6: An ALU instruction that depends on an early-ALU result in EX1 stays on the early ALU.
- R7: A chain of dependent ALU instructions that starts after a load stays on the late ALU for every link.
- R8: A LOAD or STORE in decode stalls exactly when its rs (the base) matches the destination of a late producer in EX1.
- R9: A STORE whose data register (rt) alone matches a late producer in EX1 does not stall.
- R10: ALU, ALUI, BRANCH, JUMP and NOP never stall, and the late-ALU select is 0 for every class other than ALU and ALUI.
- R11: In the clock after a stall, the EX1 slice holds class NOP with write enable 0 and late-ALU flag 0, and the held decode instruction does not stall again.
- R12: The sequence load, dependent add, then store whose base is the add result stalls the store for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_op | input | 3 | Decode instruction class code |
| id_rs | input | REG_W | Decode first source / base register |
| id_rt | input | REG_W | Decode second source / store data register |
| id_rt_rd | input | 1 | Decode instruction reads rt |
| id_ws | input | REG_W | Decode destination register |
| alu2_sel | output | 1 | Decode ALU instruction goes to the late ALU |
| stall | output | 1 | Hold decode and insert a bubble into EX1 |
| ex1_op | output | 3 | EX1 instruction class |
| ex1_ws | output | REG_W | EX1 destination register |
| ex1_we | output | 1 | EX1 writes a register |
| ex1_alu2 | output | 1 | EX1 instruction uses the late ALU |

## Verification
The bench checks that the late-ALU flag feeds back. A design that checked only for loads would drop the second and later links of a dependent chain onto the early ALU, where their operands would be stale. It applies rt matches with the read enable both set and clear, and a design that ignored the enable would steer immediate-form ops late for no reason. It checks that store data hazards do not stall and that a zero destination is harmless. It also checks that the stall bubble clears the write enable and the late-ALU flag. Without that, the held store would stall forever or leave a phantom producer behind.

// File: rtl/dual_alu_pkg.sv
package dual_alu_pkg;

  typedef enum logic [2:0] {
    OPC_NOP    = 3'd0,
    OPC_ALU    = 3'd1,
    OPC_ALUI   = 3'd2,
    OPC_LOAD   = 3'd3,
    OPC_STORE  = 3'd4,
    OPC_BRANCH = 3'd5,
    OPC_JUMP   = 3'd6
  } op_class_e;

  localparam int OP_W = 3;

  function automatic logic is_alu_op(input op_class_e op);
    return (op == OPC_ALU) || (op == OPC_ALUI);
  endfunction

  function automatic logic is_mem_op(input op_class_e op);
    return (op == OPC_LOAD) || (op == OPC_STORE);
  endfunction

  function automatic logic writes_reg(input op_class_e op);
    return is_alu_op(op) || (op == OPC_LOAD);
  endfunction

  // EX1 instruction delivers its value only at end of EX2/MEM
  function automatic logic late_producer(input op_class_e op,
                                         input logic we,
                                         input logic nonzero_dest,
                                         input logic alu2);
    return we && nonzero_dest && ((op == OPC_LOAD) || alu2);
  endfunction

endpackage

// File: rtl/alu_steer.sv
module alu_steer
  import dual_alu_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_class_e        id_op,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_rt_rd,
  input  logic [REG_W-1:0] ex1_ws,
  input  logic             ex1_late,
  output logic             alu2_sel
);

  logic rs_hit;
  logic rt_hit;
  logic src_hit;

  always_comb begin
    rs_hit   = (id_rs == ex1_ws);
    rt_hit   = id_rt_rd && (id_rt == ex1_ws);
    src_hit  = rs_hit || rt_hit;
    alu2_sel = is_alu_op(id_op) && src_hit && ex1_late;
  end

  // R10: only ALU classes may be steered late
  assert_alu2_class_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alu2_sel |-> is_alu_op(id_op));

  // R5: register zero is never a producer
  assert_alu2_zero_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex1_ws == '0) |-> !alu2_sel);

endmodule

// File: rtl/mem_interlock.sv
module mem_interlock
  import dual_alu_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_class_e        id_op,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] ex1_ws,
  input  logic             ex1_late,
  output logic             stall
);

  logic base_hit;

  always_comb begin
    base_hit = (id_rs == ex1_ws);
    stall    = is_mem_op(id_op) && base_hit && ex1_late;
  end

  // R10: non-memory classes never hold decode
  assert_no_stall_non_mem_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mem_op(id_op) |-> !stall);

  // R5: zero destination never interlocks
  assert_stall_zero_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex1_ws == '0) |-> !stall);

endmodule

// File: rtl/ex1_ctl_reg.sv
module ex1_ctl_reg
  import dual_alu_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  op_class_e        id_op,
  input  logic [REG_W-1:0] id_ws,
  input  logic             alu2_sel,
  input  logic             stall,
  output op_class_e        ex1_op,
  output logic [REG_W-1:0] ex1_ws,
  output logic             ex1_we,
  output logic             ex1_alu2
);

  always_ff @(posedge clk) begin
    if (!rst_n || stall) begin
      ex1_op   <= OPC_NOP;
      ex1_ws   <= '0;
      ex1_we   <= 1'b0;
      ex1_alu2 <= 1'b0;
    end else begin
      ex1_op   <= id_op;
      ex1_ws   <= id_ws;
      ex1_we   <= writes_reg(id_op);
      ex1_alu2 <= alu2_sel;
    end
  end

  // R11: a stall leaves a harmless bubble in EX1
  assert_bubble_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!ex1_we && !ex1_alu2 && ex1_op == OPC_NOP));

  // R2: the steering choice travels with the instruction
  assert_alu2_travels_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && alu2_sel) |=> ex1_alu2);

endmodule

// File: rtl/dual_alu_steer_ctl.sv
module dual_alu_steer_ctl
  import dual_alu_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       id_op,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_rt_rd,
  input  logic [REG_W-1:0] id_ws,
  output logic             alu2_sel,
  output logic             stall,
  output logic [2:0]       ex1_op,
  output logic [REG_W-1:0] ex1_ws,
  output logic             ex1_we,
  output logic             ex1_alu2
);

  op_class_e id_cls;
  op_class_e ex1_cls;
  logic      ex1_late;

  assign id_cls = op_class_e'(id_op);
  assign ex1_op = ex1_cls;

  // Named event: EX1 holds a value not ready until end of EX2/MEM
  assign ex1_late = late_producer(ex1_cls, ex1_we, (ex1_ws != '0), ex1_alu2);

  alu_steer #(.REG_W(REG_W)) u_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .id_op    (id_cls),
    .id_rs    (id_rs),
    .id_rt    (id_rt),
    .id_rt_rd (id_rt_rd),
    .ex1_ws   (ex1_ws),
    .ex1_late (ex1_late),
    .alu2_sel (alu2_sel)
  );

  mem_interlock #(.REG_W(REG_W)) u_interlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .id_op    (id_cls),
    .id_rs    (id_rs),
    .ex1_ws   (ex1_ws),
    .ex1_late (ex1_late),
    .stall    (stall)
  );

  ex1_ctl_reg #(.REG_W(REG_W)) u_ex1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .id_op    (id_cls),
    .id_ws    (id_ws),
    .alu2_sel (alu2_sel),
    .stall    (stall),
    .ex1_op   (ex1_cls),
    .ex1_ws   (ex1_ws),
    .ex1_we   (ex1_we),
    .ex1_alu2 (ex1_alu2)
  );

  // R12: a stall always clears in the following cycle
  assert_stall_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R10: steering and interlock never fire together
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && alu2_sel));

endmodule

// File: tb/test_dual_alu_steer_ctl.sv
module test_dual_alu_steer_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;

  localparam logic [2:0] NOP = 3'd0, ALU = 3'd1, ALUI = 3'd2, LD = 3'd3,
                         ST = 3'd4, BR = 3'd5, JMP = 3'd6;

  typedef struct packed {
    logic [2:0]    op;
    logic [RW-1:0] rs;
    logic [RW-1:0] rt;
    logic          rd;
    logic [RW-1:0] ws;
    logic          e_alu2;
    logic          e_stall;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{NOP , 5'd0 , 5'd0, 1'b0, 5'd0 , 1'b0, 1'b0, 4'd1 },  // R1
    '{LD  , 5'd2 , 5'd0, 1'b0, 5'd1 , 1'b0, 1'b0, 4'd8 },
    '{ALU , 5'd1 , 5'd4, 1'b1, 5'd3 , 1'b1, 1'b0, 4'd3 },  // R3 R10
    '{ALU , 5'd3 , 5'd6, 1'b1, 5'd5 , 1'b1, 1'b0, 4'd7 },  // R7
    '{ALU , 5'd8 , 5'd5, 1'b1, 5'd7 , 1'b1, 1'b0, 4'd4 },  // R4 rt used
    '{ST  , 5'd7 , 5'd0, 1'b1, 5'd0 , 1'b0, 1'b1, 4'd8 },  // R8
    '{ST  , 5'd7 , 5'd0, 1'b1, 5'd0 , 1'b0, 1'b0, 4'd11},  // R11
    '{ALU , 5'd10, 5'd7, 1'b1, 5'd9 , 1'b0, 1'b0, 4'd6 },
    '{ALUI, 5'd9 , 5'd0, 1'b0, 5'd1 , 1'b0, 1'b0, 4'd6 },  // R6
    '{LD  , 5'd1 , 5'd0, 1'b0, 5'd2 , 1'b0, 1'b0, 4'd8 },
    '{ALU , 5'd11, 5'd2, 1'b0, 5'd4 , 1'b0, 1'b0, 4'd4 },  // R4 rt ignored
    '{LD  , 5'd4 , 5'd0, 1'b0, 5'd0 , 1'b0, 1'b0, 4'd8 },
    '{ALU , 5'd0 , 5'd0, 1'b1, 5'd12, 1'b0, 1'b0, 4'd5 },  // R5
    '{LD  , 5'd6 , 5'd0, 1'b0, 5'd6 , 1'b0, 1'b0, 4'd8 },
    '{ST  , 5'd1 , 5'd6, 1'b1, 5'd0 , 1'b0, 1'b0, 4'd9 },  // R9
    '{LD  , 5'd3 , 5'd0, 1'b0, 5'd5 , 1'b0, 1'b0, 4'd8 },
    '{BR  , 5'd5 , 5'd5, 1'b1, 5'd0 , 1'b0, 1'b0, 4'd10},  // R10
    '{LD  , 5'd9 , 5'd0, 1'b0, 5'd8 , 1'b0, 1'b0, 4'd8 },
    '{LD  , 5'd8 , 5'd0, 1'b0, 5'd3 , 1'b0, 1'b1, 4'd8 },  // R8 load-load
    '{LD  , 5'd8 , 5'd0, 1'b0, 5'd3 , 1'b0, 1'b0, 4'd11},
    '{JMP , 5'd3 , 5'd3, 1'b1, 5'd0 , 1'b0, 1'b0, 4'd10}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    id_op = NOP;
  logic [RW-1:0] id_rs = '0, id_rt = '0, id_ws = '0;
  logic          id_rt_rd = 1'b0;
  logic          alu2_sel, stall, ex1_we, ex1_alu2;
  logic [2:0]    ex1_op;
  logic [RW-1:0] ex1_ws;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_alu_steer_ctl #(.REG_W(RW)) i_dual_alu_steer_ctl (
    .clk, .rst_n, .id_op, .id_rs, .id_rt, .id_rt_rd, .id_ws,
    .alu2_sel, .stall, .ex1_op, .ex1_ws, .ex1_we, .ex1_alu2
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Drive at negedge, inputs settle before the next rising edge
  task automatic drive(input logic [2:0] op, input logic [RW-1:0] rs,
                       input logic [RW-1:0] rt, input logic rd,
                       input logic [RW-1:0] ws);
    @(negedge clk);
    id_op = op; id_rs = rs; id_rt = rt; id_rt_rd = rd; id_ws = ws;
    #1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    drive(NOP, 0, 0, 0, 0);
    // R1: reset state
    chk("R1", "ex1_we", ex1_we, 0);
    chk("R1", "ex1_alu2", ex1_alu2, 0);
    chk("R1", "ex1_op", ex1_op, NOP);
    chk("R1", "stall", stall, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      drive(VEC[i].op, VEC[i].rs, VEC[i].rt, VEC[i].rd, VEC[i].ws);
      tag = $sformatf("R%0d#%0d", VEC[i].req, i);
      chk(tag, "alu2_sel", alu2_sel, VEC[i].e_alu2);
      chk(tag, "stall", stall, VEC[i].e_stall);
    end

    // R2: EX1 slice captures decode fields
    drive(ALU, 5'd1, 5'd2, 1'b1, 5'd13);
    drive(NOP, 0, 0, 0, 0);
    chk("R2", "ex1_op", ex1_op, ALU);
    chk("R2", "ex1_ws", ex1_ws, 13);
    chk("R2", "ex1_we", ex1_we, 1);
    drive(ST, 5'd3, 5'd4, 1'b1, 5'd9);
    drive(NOP, 0, 0, 0, 0);
    chk("R2", "store ex1_we", ex1_we, 0);

    // R12: load, add, store-on-add-result
    drive(LD, 5'd2, 0, 0, 5'd1);
    drive(ALU, 5'd1, 5'd4, 1'b1, 5'd3);
    chk("R12", "add alu2", alu2_sel, 1);
    drive(ST, 5'd3, 5'd5, 1'b1, 0);
    chk("R12", "store stall", stall, 1);
    drive(ST, 5'd3, 5'd5, 1'b1, 0);
    // R11: bubble after stall
    chk("R11", "bubble ex1_we", ex1_we, 0);
    chk("R11", "bubble ex1_alu2", ex1_alu2, 0);
    chk("R11", "bubble ex1_op", ex1_op, NOP);
    chk("R12", "store released", stall, 0);

    // R1: mid-run reset clears a late producer
    drive(LD, 5'd2, 0, 0, 5'd6);
    drive(ALU, 5'd6, 0, 0, 5'd7);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    id_op = ALU; id_rs = 5'd7; id_rt = '0; id_rt_rd = 1'b0; id_ws = 5'd8;
    #1;
    chk("R1", "post-reset ex1_alu2", ex1_alu2, 0);
    chk("R1", "post-reset alu2_sel", alu2_sel, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule